// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt pins and turns their activity into four summary interrupt requests for a higher-level interrupt controller. Every pin passes through a two-flop synchroniser and then a trigger detector. The detector can be set to react to a low level, a high level, a falling edge, a rising edge or either edge. A detected trigger sets the pin's sticky pending bit. A mask register decides which pending bits reach the summary outputs.

Software reaches the block over a small word-addressed register bus. There are two trigger-configuration registers, a mask register and a pending register. The pending register is cleared by writing ones. Each pair of neighbouring pins shares one 3-bit trigger field. The fields sit on a 4-bit stride: lines 0 to 15 use the first configuration register and lines 16 to 27 use the second. The four summary outputs cover groups of unequal size: lines 0–3, 4–11, 12–19 and 20–27.

Top module: `eig_top`

## Requirements
- R1: While reset is held, the mask register reads 0x0FFFFFFF, the pending register and both configuration registers read 0, and all four group outputs are 0.
- R2: The register word addresses are 0x0 (configuration, lines 0–15), 0x4 (configuration, lines 16–27), 0x8 (mask, bit n = line n) and 0xC (pending, bit n = line n). Read data is combinational on the address. Bits 31:28 of the mask and pending registers and bit 3 of every configuration nibble read as 0.
- R3: Line n takes its 3-bit trigger field from configuration register 0 when n < 16 and from register 1 otherwise. The field sits at bit ((n mod 16)/2)*4, so lines 2k and 2k+1 share one field.
- R4: Configuration register 1 has no fields for line indices above 27. Its bits 31:24 ignore writes and always read 0.
- R5: Field code 000 triggers while the synchronised pin is low, and code 001 triggers while it is high.
- R6: Codes 010 and 011 trigger on a falling edge only.
- R7: Codes 100 and 101 trigger on a rising edge only.
- R8: Codes 110 and 111 trigger on both edges.
- R9: When a pin changes between two clock edges, its pending bit is still 0 after the second following rising edge and becomes 1 at the third.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it as it is.
- R11: A mask bit of 1 blocks the line from its group output but does not stop the pending bit from being set. A line reaches its group only while it is pending and its mask bit is 0.
- R12: Group output 0 is the OR of the unmasked pending bits of lines 0–3. Output 1 covers lines 4–11, output 2 covers lines 12–19 and output 3 covers lines 20–27.
- R13: In a level mode the pending bit is set again on every cycle the level stays active. When a trigger and a write-one-to-clear fall in the same cycle, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 28 | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| grp_irq_o | output | 4 | Grouped interrupt requests |

## Verification
The pending register has two writers: the trigger detectors set bits and the bus clears them. Both can act on the same bit in one cycle. The bench provokes this by timing a write-one-to-clear so that its write strobe is sampled at exactly the clock edge where an edge trigger sets the bit. It also clears a line that is held at an active level. In both cases it judges the outcome by reading the pending register after that edge, and it expects the bit to remain 1. Separately, it shows that a clear issued one cycle later does take effect.

// File: rtl/eig_pkg.sv
package eig_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    TK_LEVEL = 2'd0,
    TK_FALL  = 2'd1,
    TK_RISE  = 2'd2,
    TK_BOTH  = 2'd3
  } trig_kind_e;

  // Upper two code bits choose the kind; bit 0 is level polarity in level mode.
  function automatic trig_kind_e kind_of(input logic [CODE_W-1:0] code);
    return trig_kind_e'(code[2:1]);
  endfunction

  function automatic int field_of_line(input int line);
    return line / 2;
  endfunction

  function automatic int reg_of_field(input int f, input int fields_per_reg);
    return f / fields_per_reg;
  endfunction

  function automatic int lsb_of_field(input int f, input int fields_per_reg, input int stride);
    return (f % fields_per_reg) * stride;
  endfunction

  function automatic int grp_lo(input int g);
    case (g)
      0:       return 0;
      1:       return 4;
      2:       return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int grp_hi(input int g);
    case (g)
      0:       return 3;
      1:       return 11;
      2:       return 19;
      default: return 27;
    endcase
  endfunction

endpackage

// File: rtl/eig_sync.sv
module eig_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign prev = prev_q;

  // R9: the delayed copy trails the synchronised value by exactly one cycle
  prev_trails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(lvl_q)));
endmodule

// File: rtl/eig_trig_detect.sv
module eig_trig_detect
  import eig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              lvl,
  input  logic              prev,
  output logic              hit
);
  trig_kind_e kind;
  logic       rise_ev;
  logic       fall_ev;

  assign kind    = kind_of(code);
  assign rise_ev = lvl & ~prev;
  assign fall_ev = ~lvl & prev;

  always_comb begin
    unique case (kind)
      TK_LEVEL: hit = (lvl == code[0]);
      TK_FALL:  hit = fall_ev;
      TK_RISE:  hit = rise_ev;
      default:  hit = rise_ev | fall_ev;
    endcase
  end

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_RISE && hit) |-> (lvl && !$past(lvl)));

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_FALL && hit) |-> (!lvl && $past(lvl)));

  // R8
  both_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_BOTH && hit) |-> (lvl != $past(lvl)));
endmodule

// File: rtl/eig_regfile.sv
module eig_regfile
  import eig_pkg::*;
#(
  parameter int N_LINES       = 28,
  parameter int LINES_PER_REG = 16,
  parameter int FIELD_STRIDE  = 4,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [N_LINES-1:0]             hit,
  output logic [N_LINES-1:0][CODE_W-1:0] line_code,
  output logic [N_LINES-1:0]             mask_q,
  output logic [N_LINES-1:0]             pend_q
);
  localparam int N_FIELDS       = (N_LINES + 1) / 2;
  localparam int FIELDS_PER_REG = LINES_PER_REG / 2;
  localparam int WORD_MASK      = 2;
  localparam int WORD_PEND      = 3;

  logic [1:0]              word;
  logic [N_LINES-1:0]      clr_vec;
  logic [N_LINES-1:0]      pend_d;
  logic [CODE_W-1:0]       cfg_q [N_FIELDS];
  logic                    unused_bits;

  assign word        = bus_addr[3:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  genvar f;
  generate
    for (f = 0; f < N_FIELDS; f++) begin : g_field
      localparam int RSEL = reg_of_field(f, FIELDS_PER_REG);
      localparam int LSB  = lsb_of_field(f, FIELDS_PER_REG, FIELD_STRIDE);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_q[f] <= '0;
        else if (bus_we && int'(word) == RSEL)
          cfg_q[f] <= bus_wdata[LSB +: CODE_W];
      end
    end
  endgenerate

  genvar n;
  generate
    for (n = 0; n < N_LINES; n++) begin : g_line_code
      assign line_code[n] = cfg_q[field_of_line(n)];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (bus_we && int'(word) == WORD_MASK)
      mask_q <= bus_wdata[N_LINES-1:0];
  end

  assign clr_vec = (bus_we && int'(word) == WORD_PEND) ? bus_wdata[N_LINES-1:0] : '0;
  assign pend_d  = (pend_q & ~clr_vec) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      2'd0, 2'd1: begin
        for (int k = 0; k < N_FIELDS; k++) begin
          if (reg_of_field(k, FIELDS_PER_REG) == int'(word))
            bus_rdata[lsb_of_field(k, FIELDS_PER_REG, FIELD_STRIDE) +: CODE_W] = cfg_q[k];
        end
      end
      2'd2:    bus_rdata[N_LINES-1:0] = mask_q;
      default: bus_rdata[N_LINES-1:0] = pend_q;
    endcase
  end

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec & ~hit)) == '0));

  // R11
  mask_no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));
endmodule

// File: rtl/eig_top.sv
module eig_top
  import eig_pkg::*;
#(
  parameter int N_LINES       = 28,
  parameter int LINES_PER_REG = 16,
  parameter int FIELD_STRIDE  = 4,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [27:0]       ext_irq_i,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        grp_irq_o
);
  localparam int N_GROUPS = 4;

  logic [N_LINES-1:0]             sync_lvl;
  logic [N_LINES-1:0]             sync_prev;
  logic [N_LINES-1:0]             hit;
  logic [N_LINES-1:0][CODE_W-1:0] line_code;
  logic [N_LINES-1:0]             mask_q;
  logic [N_LINES-1:0]             pend_q;
  logic [N_LINES-1:0]             status;

  eig_sync #(.W(N_LINES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ext_irq_i),
    .lvl  (sync_lvl),
    .prev (sync_prev)
  );

  genvar n;
  generate
    for (n = 0; n < N_LINES; n++) begin : g_det
      eig_trig_detect det_i (
        .clk  (clk),
        .rst_n(rst_n),
        .code (line_code[n]),
        .lvl  (sync_lvl[n]),
        .prev (sync_prev[n]),
        .hit  (hit[n])
      );
    end
  endgenerate

  eig_regfile #(
    .N_LINES      (N_LINES),
    .LINES_PER_REG(LINES_PER_REG),
    .FIELD_STRIDE (FIELD_STRIDE),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hit      (hit),
    .line_code(line_code),
    .mask_q   (mask_q),
    .pend_q   (pend_q)
  );

  assign status = pend_q & ~mask_q;

  genvar g;
  generate
    for (g = 0; g < N_GROUPS; g++) begin : g_grp
      localparam int LO = grp_lo(g);
      localparam int HI = grp_hi(g);
      assign grp_irq_o[g] = |status[HI:LO];
    end
  endgenerate

  // R12
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (grp_irq_o == '0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (grp_irq_o == '0));
endmodule

// File: tb/eig_top_tb_top.sv
module eig_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] ext_irq_i;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_cfg [2];

  always #5 clk = ~clk;

  eig_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_irq_i(ext_irq_i),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .grp_irq_o(grp_irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pend_bit(input int line, output logic b);
    logic [31:0] v;
    rd(4'hC, v);
    b = v[line];
  endtask

  task automatic clr_line(input int line);
    wr(4'hC, 32'd1 << line);
  endtask

  task automatic set_mode(input int line, input logic [2:0] code);
    int r = (line < 16) ? 0 : 1;
    int sh = ((line % 16) / 2) * 4;
    sh_cfg[r][sh +: 3] = code;
    wr(4'(r * 4), sh_cfg[r]);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(4'h8, v); chk(v == 32'h0FFFFFFF, "R1 mask reset", v, 32'h0FFFFFFF);
    rd(4'hC, v); chk(v == 32'h0, "R1 pending reset", v, 0);
    rd(4'h0, v); chk(v == 32'h0, "R1 cfg0 reset", v, 0);
    rd(4'h4, v); chk(v == 32'h0, "R1 cfg1 reset", v, 0);
    chk(grp_irq_o == 4'h0, "R1 group reset", 32'(grp_irq_o), 0);
  endtask

  task automatic test_regmap();
    logic [31:0] v;
    wr(4'h0, 32'hFFFFFFFF); rd(4'h0, v);
    chk(v == 32'h77777777, "R2 cfg0 nibble bit3 zero", v, 32'h77777777);
    wr(4'h0, sh_cfg[0]);
    wr(4'h4, 32'hFFFFFFFF); rd(4'h4, v);
    chk(v == 32'h00777777, "R4 cfg1 upper bits rejected", v, 32'h00777777);
    wr(4'h4, sh_cfg[1]);
    wr(4'h8, 32'hFFFFFFFF); rd(4'h8, v);
    chk(v == 32'h0FFFFFFF, "R2 mask upper bits zero", v, 32'h0FFFFFFF);
    wr(4'h8, 32'h0); rd(4'h8, v);
    chk(v == 32'h0, "R2 mask clear", v, 0);
    wr(4'h8, 32'h0FFFFFFF);
    set_mode(23, 3'b110); rd(4'h4, v);
    chk(v == 32'h00446444, "R3 field position line 23", v, 32'h00446444);
  endtask

  task automatic test_shared_field();
    logic b;
    ext_irq_i[22] = 1'b0; tick(4);
    pend_bit(22, b);
    chk(b == 1'b1, "R3 line 22 shares both-edge field of 23", 32'(b), 1);
    clr_line(22);
    ext_irq_i[22] = 1'b1; tick(4);
    set_mode(23, 3'b100); tick(1); clr_line(22); tick(1);
  endtask

  task automatic test_edge(input int line, input logic [2:0] code, input string req,
                           input bit exp_fall, input bit exp_rise);
    logic b;
    set_mode(line, code); tick(2); clr_line(line); tick(1);
    ext_irq_i[line] = 1'b0; tick(4);
    pend_bit(line, b);
    chk(b == exp_fall, {req, " falling"}, 32'(b), 32'(exp_fall));
    clr_line(line); tick(1);
    ext_irq_i[line] = 1'b1; tick(4);
    pend_bit(line, b);
    chk(b == exp_rise, {req, " rising"}, 32'(b), 32'(exp_rise));
    set_mode(line, 3'b100); clr_line(line); tick(1);
  endtask

  task automatic test_level(input int line, input logic [2:0] code);
    logic b;
    logic act = code[0];
    ext_irq_i[line] = ~act;
    set_mode(line, code); tick(4); clr_line(line); tick(1);
    pend_bit(line, b); chk(b == 1'b0, "R5 inactive level", 32'(b), 0);
    ext_irq_i[line] = act; tick(4);
    pend_bit(line, b); chk(b == 1'b1, "R5 active level", 32'(b), 1);
    clr_line(line);
    pend_bit(line, b); chk(b == 1'b1, "R13 level re-sets after clear", 32'(b), 1);
    ext_irq_i[line] = ~act; tick(4); clr_line(line); tick(1);
    pend_bit(line, b); chk(b == 1'b0, "R5 clear holds after deassert", 32'(b), 0);
    ext_irq_i[line] = 1'b1; set_mode(line, 3'b100); tick(4); clr_line(line); tick(1);
  endtask

  task automatic test_latency();
    logic b;
    ext_irq_i[6] = 1'b0; tick(4); clr_line(6); tick(1);
    ext_irq_i[6] = 1'b1; tick(2);
    pend_bit(6, b); chk(b == 1'b0, "R9 not yet pending after two edges", 32'(b), 0);
    tick(1);
    pend_bit(6, b); chk(b == 1'b1, "R9 pending at third edge", 32'(b), 1);
    clr_line(6);
  endtask

  task automatic test_w1c();
    logic [31:0] v;
    ext_irq_i[2:1] = 2'b00; tick(4); wr(4'hC, 32'h6); tick(1);
    ext_irq_i[2:1] = 2'b11; tick(4);
    wr(4'hC, 32'h2); rd(4'hC, v);
    chk(v[2:1] == 2'b10, "R10 write one clears only that bit", 32'(v[2:1]), 32'h2);
    wr(4'hC, 32'h0); rd(4'hC, v);
    chk(v[2] == 1'b1, "R10 write zero keeps bit", 32'(v[2]), 1);
    wr(4'hC, 32'h4);
  endtask

  task automatic test_groups();
    logic b;
    int lines [6] = '{3, 4, 11, 19, 20, 27};
    int grps  [6] = '{0, 1, 1, 2, 3, 3};
    ext_irq_i[12] = 1'b0; tick(4); clr_line(12); tick(1);
    ext_irq_i[12] = 1'b1; tick(4);
    pend_bit(12, b);
    chk(b == 1'b1 && grp_irq_o == 4'h0, "R11 masked line pends but stays quiet",
        {27'(0), grp_irq_o, b}, 32'h1);
    wr(4'h8, 32'h0FFFFFFF & ~(32'd1 << 12));
    chk(grp_irq_o == 4'b0100, "R11 unmask releases pending line", 32'(grp_irq_o), 32'h4);
    clr_line(12); wr(4'h8, 32'h0FFFFFFF);
    for (int i = 0; i < 6; i++) begin
      wr(4'h8, 32'h0FFFFFFF & ~(32'd1 << lines[i]));
      ext_irq_i[lines[i]] = 1'b0; tick(4); clr_line(lines[i]); tick(1);
      ext_irq_i[lines[i]] = 1'b1; tick(4);
      chk(grp_irq_o == (4'd1 << grps[i]), $sformatf("R12 line %0d group", lines[i]),
          32'(grp_irq_o), 32'd1 << grps[i]);
      clr_line(lines[i]);
      chk(grp_irq_o == 4'h0, "R12 group drops after clear", 32'(grp_irq_o), 0);
    end
    wr(4'h8, 32'h0FFFFFFF);
  endtask

  task automatic test_race();
    logic b;
    ext_irq_i[8] = 1'b0; tick(4); clr_line(8); tick(1);
    ext_irq_i[8] = 1'b1; tick(2);
    bus_we = 1'b1; bus_addr = 4'hC; bus_wdata = 32'd1 << 8;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    pend_bit(8, b); chk(b == 1'b1, "R13 trigger wins over same-cycle clear", 32'(b), 1);
    clr_line(8);
    pend_bit(8, b); chk(b == 1'b0, "R13 later clear takes effect", 32'(b), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    ext_irq_i = '1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    sh_cfg[0] = 32'h44444444;
    sh_cfg[1] = 32'h00444444;
    tick(3);
    test_reset();
    rst_n = 1'b1;
    tick(1);
    wr(4'h0, sh_cfg[0]); wr(4'h4, sh_cfg[1]);
    tick(5); wr(4'hC, 32'h0FFFFFFF); tick(1);
    begin
      logic [31:0] v;
      rd(4'hC, v); chk(v == 32'h0, "R7 steady high inputs raise nothing", v, 0);
    end
    test_regmap();
    test_shared_field();
    test_edge(0, 3'b100, "R7 code 100", 1'b0, 1'b1);
    test_edge(9, 3'b101, "R7 code 101", 1'b0, 1'b1);
    test_edge(16, 3'b010, "R6 code 010", 1'b1, 1'b0);
    test_edge(27, 3'b011, "R6 code 011", 1'b1, 1'b0);
    test_edge(5, 3'b110, "R8 code 110", 1'b1, 1'b1);
    test_edge(20, 3'b111, "R8 code 111", 1'b1, 1'b1);
    test_level(10, 3'b000);
    test_level(25, 3'b001);
    test_latency();
    test_w1c();
    test_groups();
    test_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule